// File: doc/BRIEF.md
# Data-Phase Handshake Monitor

This block watches a shared 32-bit multiplexed bus from the side and drives nothing on it. On every rising clock edge it samples the frame, device-select, initiator-ready and target-ready strobes, the active-low byte enables, the data lines, a read/write flag and a flag that shows when the target is driving the data lines. From these samples it recognises completed data transfers and counts them within each transaction. It also checks three handshake rules: a ready strobe may not be withdrawn before its data phase completes, a read must leave the cycle after the address free for bus turnaround, and a transfer may not complete before the target has claimed the transaction.

Each completed transfer's word and byte-enable mask leave the block on a one-entry valid/ready stream. The monitor cannot stall the bus, so back-pressure cannot reach the source. A word waits in the output slot until the consumer takes it. A completion that arrives while the slot is full and is not being emptied on that edge is dropped. A consumer that keeps `cap_ready` high receives every word, including bursts that complete one word per clock.

Each rule violation gives a one-cycle pulse. It also sets a flag that stays set until software-independent logic raises the synchronous clear.

Top module: `dphs_monitor`

## Requirements
- R1: A transfer completes on a sampling edge where `bus_irdy_n` and `bus_trdy_n` are both low. The captured word and mask are the `bus_data` and `bus_be_n` values present on that edge. Values seen during earlier wait states are never captured.
- R2: An address phase is an edge where `bus_frame_n` is low and was high on the previous edge. On that edge `xfer_count` goes to 0. Each later completion adds 1, and the counter wraps at its width.
- R3: While both ready strobes stay low on consecutive edges, one word completes per edge. With `cap_ready` held high, each word appears on the stream in bus order, one edge after it completes.
- R4: Once `cap_valid` is high, it and `cap_data`/`cap_be_n`/`cap_nodata` hold steady until an edge where `cap_ready` is high. That edge empties the slot. If a completion occurs on the same edge, the new word is loaded instead.
- R5: A completion on an edge where the slot is full and `cap_ready` is low is discarded and the held word stays unchanged. The completion is still counted.
- R6: A completion with all four byte enables high (`4'b1111`) is counted and placed on the stream with `cap_nodata`=1. Any other mask gives `cap_nodata`=0.
- R7: A stability violation (flag bit 0) fires when a ready strobe was low on the previous edge, no transfer completed on that edge, and the strobe is high now.
- R8: A turnaround violation (flag bit 1) fires on the edge after the address phase of a read (`bus_read`=1 sampled at the address phase) if `bus_trdy_n` is low or `bus_tgt_drv` is high. Writes are exempt.
- R9: An early-transfer violation (flag bit 2) fires when a completion occurs and `bus_devsel_n` has not been low on any edge since the address phase, including the current edge.
- R10: `viol_pulse[i]` is high for exactly the one cycle after the offending edge. `viol_sticky[i]` rises at the same time and stays high afterwards.
- R11: `clr_flags` clears all sticky flags on the next edge. If a violation fires on that same edge, its flag is set rather than cleared.
- R12: After reset, `cap_valid`, `xfer_count`, `viol_pulse` and `viol_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_flags | input | 1 | Synchronous clear of the sticky violation flags |
| bus_frame_n | input | 1 | Frame strobe, active low |
| bus_devsel_n | input | 1 | Device-select strobe, active low |
| bus_irdy_n | input | 1 | Initiator-ready strobe, active low |
| bus_trdy_n | input | 1 | Target-ready strobe, active low |
| bus_be_n | input | BE_W | Byte enables, active low |
| bus_data | input | DATA_W | Shared data lines |
| bus_read | input | 1 | 1 = read transaction, sampled at the address phase |
| bus_tgt_drv | input | 1 | 1 = target is driving the data lines |
| cap_valid | output | 1 | Captured word available |
| cap_ready | input | 1 | Consumer accepts the captured word |
| cap_data | output | DATA_W | Captured word |
| cap_be_n | output | BE_W | Byte-enable mask captured with the word |
| cap_nodata | output | 1 | Captured phase had no byte enabled |
| xfer_count | output | CNT_W | Completions in the current transaction |
| viol_pulse | output | 3 | One-cycle violation pulses: bit0 stability, bit1 turnaround, bit2 early |
| viol_sticky | output | 3 | Sticky violation flags, same bit order |

## Verification
The embedded properties assume that every input is a clean, settled level at each rising edge. They also assume that `cap_ready` is driven only by the consumer and not derived from `cap_valid` on the same edge. The bench meets both assumptions by changing every input on the falling edge and reading outputs one falling edge after the edge that acts on them. Each transaction starts from an idle cycle with the frame strobe high, so that every address phase is seen as a fresh falling frame. Violation scenarios are kept separate from legal ones, so that each rule's pulse can be attributed to a single cause.

// File: rtl/dphs_pkg.sv
package dphs_pkg;
  localparam int NUM_VIOL = 3;
  localparam int V_STAB   = 0;
  localparam int V_TURN   = 1;
  localparam int V_EARLY  = 2;
endpackage

// File: rtl/dphs_phase_track.sv
module dphs_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic devsel_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic rd,
  output logic addr_ph,
  output logic second_ph,
  output logic rd_txn,
  output logic dsel_now,
  output logic xfer,
  output logic irdy_held,
  output logic trdy_held
);
  logic frame_q, second_q, rd_q, dsel_q, irdy_low_q, trdy_low_q, xfer_q;

  assign addr_ph   = ~frame_n & frame_q;
  assign second_ph = second_q;
  assign rd_txn    = rd_q;
  assign xfer      = ~irdy_n & ~trdy_n;
  assign dsel_now  = ~devsel_n | (dsel_q & ~addr_ph);
  assign irdy_held = irdy_low_q & ~xfer_q;
  assign trdy_held = trdy_low_q & ~xfer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q    <= 1'b1;
      second_q   <= 1'b0;
      rd_q       <= 1'b0;
      dsel_q     <= 1'b0;
      irdy_low_q <= 1'b0;
      trdy_low_q <= 1'b0;
      xfer_q     <= 1'b0;
    end else begin
      frame_q    <= frame_n;
      second_q   <= addr_ph;
      if (addr_ph) rd_q <= rd;
      dsel_q     <= dsel_now;
      irdy_low_q <= ~irdy_n;
      trdy_low_q <= ~trdy_n;
      xfer_q     <= xfer;
    end
  end
endmodule

// File: rtl/dphs_rule_check.sv
module dphs_rule_check
  import dphs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_flags,
  input  logic                irdy_n,
  input  logic                trdy_n,
  input  logic                tgt_drv,
  input  logic                second_ph,
  input  logic                rd_txn,
  input  logic                dsel_now,
  input  logic                xfer,
  input  logic                irdy_held,
  input  logic                trdy_held,
  output logic [NUM_VIOL-1:0] pulse,
  output logic [NUM_VIOL-1:0] sticky
);
  logic [NUM_VIOL-1:0] fire;

  assign fire[V_STAB]  = (irdy_held & irdy_n) | (trdy_held & trdy_n);
  assign fire[V_TURN]  = second_ph & rd_txn & (~trdy_n | tgt_drv);
  assign fire[V_EARLY] = xfer & ~dsel_now;

  for (genvar i = 0; i < NUM_VIOL; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pulse[i]  <= 1'b0;
        sticky[i] <= 1'b0;
      end else begin
        pulse[i]  <= fire[i];
        sticky[i] <= fire[i] | (sticky[i] & ~clr_flags);
      end
    end

    // R10
    pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |-> sticky[i]);

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky[i] && !clr_flags) |=> sticky[i]);
  end
endmodule

// File: rtl/dphs_capture.sv
module dphs_capture #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ph,
  input  logic              xfer,
  input  logic [DATA_W-1:0] data,
  input  logic [BE_W-1:0]   be_n,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be_n,
  output logic              out_nodata,
  output logic [CNT_W-1:0]  count
);
  logic slot_free, load;

  assign slot_free = ~out_valid | out_ready;
  assign load      = xfer & slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_be_n   <= '0;
      out_nodata <= 1'b0;
      count      <= '0;
    end else begin
      if (load) begin
        out_valid  <= 1'b1;
        out_data   <= data;
        out_be_n   <= be_n;
        out_nodata <= &be_n;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
      if (addr_ph)   count <= '0;
      else if (xfer) count <= count + 1'b1;
    end
  end

  // R4
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be_n)));

  // R2
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |=> (count == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !addr_ph) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/dphs_monitor.sv
module dphs_monitor
  import dphs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_flags,
  input  logic              bus_frame_n,
  input  logic              bus_devsel_n,
  input  logic              bus_irdy_n,
  input  logic              bus_trdy_n,
  input  logic [BE_W-1:0]   bus_be_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_read,
  input  logic              bus_tgt_drv,
  output logic              cap_valid,
  input  logic              cap_ready,
  output logic [DATA_W-1:0] cap_data,
  output logic [BE_W-1:0]   cap_be_n,
  output logic              cap_nodata,
  output logic [CNT_W-1:0]  xfer_count,
  output logic [NUM_VIOL-1:0] viol_pulse,
  output logic [NUM_VIOL-1:0] viol_sticky
);
  logic addr_ph, second_ph, rd_txn, dsel_now, xfer, irdy_held, trdy_held;

  dphs_phase_track u_trk (
    .clk(clk), .rst_n(rst_n), .frame_n(bus_frame_n), .devsel_n(bus_devsel_n),
    .irdy_n(bus_irdy_n), .trdy_n(bus_trdy_n), .rd(bus_read),
    .addr_ph(addr_ph), .second_ph(second_ph), .rd_txn(rd_txn), .dsel_now(dsel_now),
    .xfer(xfer), .irdy_held(irdy_held), .trdy_held(trdy_held)
  );

  dphs_rule_check u_rules (
    .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags), .irdy_n(bus_irdy_n),
    .trdy_n(bus_trdy_n), .tgt_drv(bus_tgt_drv), .second_ph(second_ph),
    .rd_txn(rd_txn), .dsel_now(dsel_now), .xfer(xfer), .irdy_held(irdy_held),
    .trdy_held(trdy_held), .pulse(viol_pulse), .sticky(viol_sticky)
  );

  dphs_capture #(.DATA_W(DATA_W), .BE_W(BE_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .addr_ph(addr_ph), .xfer(xfer), .data(bus_data),
    .be_n(bus_be_n), .out_ready(cap_ready), .out_valid(cap_valid),
    .out_data(cap_data), .out_be_n(cap_be_n), .out_nodata(cap_nodata),
    .count(xfer_count)
  );

  // R1
  completion_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_count != $past(xfer_count) && xfer_count != '0) |-> $past(xfer));
endmodule

// File: tb/tb_dphs_monitor.sv
module tb_dphs_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_flags = 1'b0;
  logic        frame_n = 1'b1, devsel_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] data = '0;
  logic        rd = 1'b0, tdrv = 1'b0;
  logic        cap_ready = 1'b1;
  logic        cap_valid, cap_nodata;
  logic [31:0] cap_data;
  logic [3:0]  cap_be_n;
  logic [7:0]  xfer_count;
  logic [2:0]  viol_pulse, viol_sticky;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dphs_monitor dut (
    .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags), .bus_frame_n(frame_n),
    .bus_devsel_n(devsel_n), .bus_irdy_n(irdy_n), .bus_trdy_n(trdy_n),
    .bus_be_n(be_n), .bus_data(data), .bus_read(rd), .bus_tgt_drv(tdrv),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_data(cap_data),
    .cap_be_n(cap_be_n), .cap_nodata(cap_nodata), .xfer_count(xfer_count),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one bus cycle on the falling edge, let one rising edge act, return at the next falling edge
  task automatic cyc(logic f, logic dv, logic ir, logic tr, logic [3:0] be, logic [31:0] d);
    frame_n = f; devsel_n = dv; irdy_n = ir; trdy_n = tr; be_n = be; data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rd = 1'b0; tdrv = 1'b0; clr_flags = 1'b0;
    cyc(1, 1, 1, 1, 4'hF, 32'h0);
  endtask

  task automatic clear_flags();
    clr_flags = 1'b1;
    cyc(1, 1, 1, 1, 4'hF, 32'h0);
    clr_flags = 1'b0;
    check("R11 cleared", {61'd0, viol_sticky}, 64'd0);
  endtask

  task automatic t_reset();
    check("R12 valid", {63'd0, cap_valid}, 64'd0);
    check("R12 count", {56'd0, xfer_count}, 64'd0);
    check("R12 pulse", {61'd0, viol_pulse}, 64'd0);
    check("R12 sticky", {61'd0, viol_sticky}, 64'd0);
  endtask

  task automatic t_wait_states();
    rd = 1'b0;
    cyc(0, 1, 1, 1, 4'h0, 32'h11);
    check("R2 count at address", {56'd0, xfer_count}, 64'd0);
    cyc(0, 0, 1, 1, 4'h0, 32'hAAAA0001);
    cyc(0, 0, 0, 1, 4'h0, 32'hAAAA0002);
    check("R1 no capture while target waits", {63'd0, cap_valid}, 64'd0);
    cyc(0, 0, 0, 0, 4'h0, 32'hCAFE0003);
    check("R1 valid", {63'd0, cap_valid}, 64'd1);
    check("R1 data", {32'd0, cap_data}, {32'd0, 32'hCAFE0003});
    check("R2 count 1", {56'd0, xfer_count}, 64'd1);
    cyc(0, 0, 1, 0, 4'h0, 32'hAAAA0004);
    check("R1 slot emptied, no capture", {63'd0, cap_valid}, 64'd0);
    cyc(1, 0, 0, 0, 4'b1010, 32'hBEEF0005);
    check("R1 data 2", {32'd0, cap_data}, {32'd0, 32'hBEEF0005});
    check("R1 mask 2", {60'd0, cap_be_n}, {60'd0, 4'b1010});
    check("R2 count 2", {56'd0, xfer_count}, 64'd2);
    idle();
    check("R7 no violation in legal waits", {61'd0, viol_sticky}, 64'd0);
  endtask

  task automatic t_burst();
    logic [3:0] bes [4] = '{4'h0, 4'hF, 4'h3, 4'h0};
    rd = 1'b0;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    check("R2 restart", {56'd0, xfer_count}, 64'd0);
    cyc(0, 0, 1, 1, 4'h0, 32'h0);
    for (int k = 0; k < 4; k++) begin
      cyc((k == 3), 0, 0, 0, bes[k], 32'h1000 + k);
      check("R3 data", {32'd0, cap_data}, 64'h1000 + k);
      check("R3 count", {56'd0, xfer_count}, k + 1);
      check("R6 nodata", {63'd0, cap_nodata}, (k == 1) ? 64'd1 : 64'd0);
    end
    idle();
    check("R3 no violation", {61'd0, viol_sticky}, 64'd0);
  endtask

  task automatic t_backpressure();
    rd = 1'b0; cap_ready = 1'b0;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    cyc(0, 0, 1, 1, 4'h0, 32'h0);
    cyc(0, 0, 0, 0, 4'h0, 32'hD1);
    check("R4 held valid", {63'd0, cap_valid}, 64'd1);
    cyc(0, 0, 0, 0, 4'h5, 32'hD2);
    check("R5 held word kept", {32'd0, cap_data}, 64'hD1);
    check("R5 mask kept", {60'd0, cap_be_n}, 64'h0);
    check("R5 still counted", {56'd0, xfer_count}, 64'd2);
    cap_ready = 1'b1;
    cyc(1, 0, 0, 0, 4'h0, 32'hD3);
    check("R4 accept and reload", {63'd0, cap_valid}, 64'd1);
    check("R4 new word", {32'd0, cap_data}, 64'hD3);
    idle();
    check("R4 drained", {63'd0, cap_valid}, 64'd0);
  endtask

  task automatic t_stability();
    rd = 1'b0;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    cyc(0, 0, 0, 1, 4'h0, 32'h0);
    cyc(0, 0, 1, 1, 4'h0, 32'h0);
    check("R7 pulse", {61'd0, viol_pulse}, 64'b001);
    check("R10 sticky", {61'd0, viol_sticky}, 64'b001);
    cyc(0, 0, 1, 1, 4'h0, 32'h0);
    check("R10 pulse one cycle", {61'd0, viol_pulse}, 64'd0);
    check("R10 sticky stays", {61'd0, viol_sticky}, 64'b001);
    cyc(0, 0, 1, 0, 4'h0, 32'h0);
    clr_flags = 1'b1;
    cyc(0, 0, 1, 1, 4'h0, 32'h0);
    clr_flags = 1'b0;
    check("R11 fire wins over clear", {61'd0, viol_sticky}, 64'b001);
    idle();
    clear_flags();
  endtask

  task automatic t_turnaround();
    rd = 1'b1;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    rd = 1'b0;
    cyc(0, 0, 1, 0, 4'h0, 32'h0);
    check("R8 ready in turnaround", {61'd0, viol_pulse}, 64'b010);
    cyc(1, 0, 0, 0, 4'h0, 32'h7);
    idle();
    clear_flags();
    rd = 1'b1;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    rd = 1'b0; tdrv = 1'b1;
    cyc(0, 0, 1, 1, 4'h0, 32'h0);
    check("R8 drive in turnaround", {61'd0, viol_pulse}, 64'b010);
    tdrv = 1'b0;
    idle();
    clear_flags();
    rd = 1'b1;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    rd = 1'b0;
    cyc(0, 0, 0, 1, 4'h0, 32'h0);
    tdrv = 1'b1;
    cyc(1, 0, 0, 0, 4'h0, 32'h8);
    tdrv = 1'b0;
    check("R8 legal read", {61'd0, viol_sticky}, 64'd0);
    idle();
    rd = 1'b0;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    cyc(0, 0, 1, 0, 4'h0, 32'h0);
    check("R8 write exempt", {61'd0, viol_pulse}, 64'd0);
    cyc(1, 0, 0, 0, 4'h0, 32'h9);
    idle();
    check("R8 write clean", {61'd0, viol_sticky}, 64'd0);
  endtask

  task automatic t_early();
    rd = 1'b0;
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    cyc(1, 1, 0, 0, 4'h0, 32'hE1);
    check("R9 early pulse", {61'd0, viol_pulse}, 64'b100);
    check("R9 still counted", {56'd0, xfer_count}, 64'd1);
    idle();
    clear_flags();
    cyc(0, 1, 1, 1, 4'h0, 32'h0);
    cyc(1, 0, 0, 0, 4'h0, 32'hE2);
    check("R9 same-edge select legal", {61'd0, viol_pulse}, 64'd0);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        idle();
        t_wait_states();
        t_burst();
        t_backpressure();
        t_stability();
        t_turnaround();
        t_early();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule